// File: doc/BRIEF.md
# SPI NOR Block-Erase Sequencer

This block erases one 32 KB or 64 KB block of an external SPI NOR flash without help from software. A single `start` request carries the block size and a 24-bit address. The block then runs a whole transaction on its own. It sends a write-enable frame. It sends the erase frame, whose opcode depends on the size. Raising chip select afterwards launches the erase inside the device. It then reads the status register again and again until the device reports that it is no longer busy.

The serial side runs in SPI mode 0. SCK rests low and the host changes its data output while SCK is low. The SCK half period is set at run time through `clk_div`, and the chip-select idle time between frames is set through `cs_gap`. The number of status reads is limited by `poll_limit`. The transaction ends with a one-cycle `done` pulse when the device is ready, or a one-cycle `timeout` pulse when the limit runs out.

The input data line can pass through a configurable synchronizer. The depth is set by `SYNC_STAGES`, and `clk_div` must exceed `SYNC_STAGES - 1`.

Top module: `spi_block_erase`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `timeout` are 0.
- R2: A `start` seen while idle sets `busy` on the next cycle. Size and address are captured at that moment. A `start` while busy is ignored: it adds no frames, and changes to the inputs after acceptance do not alter the frames that follow.
- R3: The first frame of a transaction is exactly 8 bits long and carries 0x06, MSB first. Chip select rises after it.
- R4: The second frame is 32 bits long. It carries an opcode first, 0x52 when `size64`=0 or 0xD8 when `size64`=1, then address bits 23 down to 0, MSB first. All address bits are sent unchanged, including those below the block boundary.
- R5: SPI mode 0 applies. SCK is 0 whenever chip select is high, `spi_mosi` holds steady while SCK stays high, `spi_miso` is sampled on the SCK rising edge, and each SCK high phase lasts `clk_div`+1 clock cycles.
- R6: Between frames of one transaction, chip select stays high for at least max(`cs_gap`,1) clock cycles.
- R7: After the erase frame, each status poll is a 16-bit frame. It starts with opcode 0x05, and the last 8 bits are read from `spi_miso`. Only bit 0 of the returned byte (busy) is used, and the other seven bits have no effect.
- R8: When a status byte shows bit 0 = 0, `done` pulses for exactly one cycle, `busy` falls in that same cycle, and no further frame follows.
- R9: If max(`poll_limit`,1) status reads in a row all show bit 0 = 1, `timeout` pulses for one cycle, `busy` falls, and `done` stays low.
- R10: `done` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase transaction (taken when idle) |
| size64 | input | 1 | 1 selects 64 KB block, 0 selects 32 KB |
| blk_addr | input | 24 | Address inside the block to erase |
| clk_div | input | DIV_W | SCK half period minus one, in clocks |
| cs_gap | input | GAP_W | Minimum chip-select high time between frames |
| poll_limit | input | POLL_W | Maximum number of status reads (0 acts as 1) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: erase finished |
| timeout | output | 1 | One-cycle pulse: poll limit reached while busy |

## Verification
The hardest cases to reach are the poll-count boundaries: the device must stay busy for exactly the limit, one read fewer, or forever with a zero limit. The bench models the flash behaviourally. Its status reply keeps bit 0 set for a programmed number of reads and keeps the other seven bits set throughout. This lets each boundary be hit deliberately. A second `start` and a changed address are injected mid-transaction to show that the captured request stays fixed.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

   localparam int FRAME_W  = 32;
   localparam int CNT_W    = 6;
   localparam int ADDR_W   = 24;

   localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
   localparam logic [7:0] OPC_ERASE_32K = 8'h52;
   localparam logic [7:0] OPC_ERASE_64K = 8'hD8;
   localparam logic [7:0] OPC_READ_STAT = 8'h05;

   typedef enum logic [1:0] {
      FK_WREN,
      FK_ERASE,
      FK_POLL
   } frame_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_FRAME,
      SQ_GAP
   } seq_state_e;

   typedef enum logic [1:0] {
      BE_IDLE,
      BE_SHIFT,
      BE_TAIL
   } eng_state_e;

endpackage

// File: rtl/spi_erase_sync.sv
module spi_erase_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[0] <= 1'b0;
                  else        stage_q[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= 1'b0;
                  else        stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_erase_half_tick.sv
module spi_erase_half_tick #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         tick
);
   logic [W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_erase_bit_engine.sv
module spi_erase_bit_engine
   import spi_erase_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    go,
   input  logic [FRAME_W-1:0]      tx_word,
   input  logic [CNT_W-1:0]        tx_bits,
   input  logic [DIV_W-1:0]        div,
   input  logic                    miso,
   output logic                    sck,
   output logic                    cs_n,
   output logic                    mosi,
   output logic [7:0]              rx_byte,
   output logic                    fin
);
   eng_state_e           st_q;
   logic [FRAME_W-1:0]   shreg_q;
   logic [CNT_W-1:0]     left_q;
   logic                 tick;
   logic                 miso_s;

   spi_erase_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (miso),
      .q    (miso_s)
   );

   spi_erase_half_tick #(.W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st_q != BE_IDLE),
      .limit(div),
      .tick (tick)
   );

   assign mosi = shreg_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= BE_IDLE;
         shreg_q <= '0;
         left_q  <= '0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         rx_byte <= '0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (st_q)
            BE_IDLE: begin
               if (go) begin
                  cs_n    <= 1'b0;
                  shreg_q <= tx_word;
                  left_q  <= tx_bits;
                  st_q    <= BE_SHIFT;
               end
            end
            BE_SHIFT: begin
               if (tick) begin
                  if (!sck) begin
                     sck     <= 1'b1;
                     rx_byte <= {rx_byte[6:0], miso_s};
                  end else begin
                     sck    <= 1'b0;
                     left_q <= left_q - 1'b1;
                     if (left_q == CNT_W'(1)) st_q <= BE_TAIL;
                     else                     shreg_q <= shreg_q << 1;
                  end
               end
            end
            BE_TAIL: begin
               if (tick) begin
                  cs_n <= 1'b1;
                  fin  <= 1'b1;
                  st_q <= BE_IDLE;
               end
            end
            default: st_q <= BE_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_erase_seq_ctrl.sv
module spi_erase_seq_ctrl
   import spi_erase_pkg::*;
#(
   parameter int GAP_W    = 8,
   parameter int POLL_W   = 16,
   parameter int BUSY_BIT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                size64,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [GAP_W-1:0]    gap,
   input  logic [POLL_W-1:0]   poll_limit,
   input  logic                eng_fin,
   input  logic [7:0]          rx_byte,
   output logic                go,
   output logic [FRAME_W-1:0]  tx_word,
   output logic [CNT_W-1:0]    tx_bits,
   output logic                busy,
   output logic                done,
   output logic                timeout
);
   seq_state_e          st_q;
   frame_kind_e         kind_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [7:0]          op_q;
   logic [GAP_W-1:0]    gap_cnt_q;
   logic [POLL_W-1:0]   poll_cnt_q;
   logic                gap_last;
   logic                poll_last;

   assign gap_last  = (gap == '0) || (gap_cnt_q == gap - 1'b1);
   assign poll_last = (poll_limit == '0) || (poll_cnt_q == poll_limit - 1'b1);

   always_comb begin
      unique case (kind_q)
         FK_WREN: begin
            tx_word = {OPC_WR_ENABLE, {ADDR_W{1'b0}}};
            tx_bits = CNT_W'(8);
         end
         FK_ERASE: begin
            tx_word = {op_q, addr_q};
            tx_bits = CNT_W'(32);
         end
         default: begin
            tx_word = {OPC_READ_STAT, {ADDR_W{1'b0}}};
            tx_bits = CNT_W'(16);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         kind_q     <= FK_WREN;
         addr_q     <= '0;
         op_q       <= '0;
         gap_cnt_q  <= '0;
         poll_cnt_q <= '0;
         go         <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
         timeout    <= 1'b0;
      end else begin
         go      <= 1'b0;
         done    <= 1'b0;
         timeout <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  busy       <= 1'b1;
                  kind_q     <= FK_WREN;
                  addr_q     <= addr;
                  op_q       <= size64 ? OPC_ERASE_64K : OPC_ERASE_32K;
                  poll_cnt_q <= '0;
                  go         <= 1'b1;
                  st_q       <= SQ_FRAME;
               end
            end
            SQ_FRAME: begin
               gap_cnt_q <= '0;
               if (eng_fin) begin
                  unique case (kind_q)
                     FK_WREN: begin
                        kind_q <= FK_ERASE;
                        st_q   <= SQ_GAP;
                     end
                     FK_ERASE: begin
                        kind_q <= FK_POLL;
                        st_q   <= SQ_GAP;
                     end
                     default: begin
                        if (!rx_byte[BUSY_BIT]) begin
                           done <= 1'b1;
                           busy <= 1'b0;
                           st_q <= SQ_IDLE;
                        end else if (poll_last) begin
                           timeout <= 1'b1;
                           busy    <= 1'b0;
                           st_q    <= SQ_IDLE;
                        end else begin
                           poll_cnt_q <= poll_cnt_q + 1'b1;
                           st_q       <= SQ_GAP;
                        end
                     end
                  endcase
               end
            end
            SQ_GAP: begin
               if (gap_last) begin
                  go   <= 1'b1;
                  st_q <= SQ_FRAME;
               end else begin
                  gap_cnt_q <= gap_cnt_q + 1'b1;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_block_erase.sv
module spi_block_erase
   import spi_erase_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int GAP_W       = 8,
   parameter int POLL_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              size64,
   input  logic [23:0]       blk_addr,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic [GAP_W-1:0]  cs_gap,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              busy,
   output logic              done,
   output logic              timeout
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must be within 1..16");
      end
      if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
         $error("GAP_W must be within 1..16");
      end
      if (POLL_W < 1 || POLL_W > 32) begin : g_bad_poll
         $error("POLL_W must be within 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
      if (BUSY_BIT < 0 || BUSY_BIT > 7) begin : g_bad_bit
         $error("BUSY_BIT must index the status byte");
      end
   endgenerate

   logic                go;
   logic                fin;
   logic [FRAME_W-1:0]  tx_word;
   logic [CNT_W-1:0]    tx_bits;
   logic [7:0]          rx_byte;

   spi_erase_seq_ctrl #(
      .GAP_W   (GAP_W),
      .POLL_W  (POLL_W),
      .BUSY_BIT(BUSY_BIT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .size64    (size64),
      .addr      (blk_addr),
      .gap       (cs_gap),
      .poll_limit(poll_limit),
      .eng_fin   (fin),
      .rx_byte   (rx_byte),
      .go        (go),
      .tx_word   (tx_word),
      .tx_bits   (tx_bits),
      .busy      (busy),
      .done      (done),
      .timeout   (timeout)
   );

   spi_erase_bit_engine #(
      .DIV_W      (DIV_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .tx_word(tx_word),
      .tx_bits(tx_bits),
      .div    (clk_div),
      .miso   (spi_miso),
      .sck    (spi_sck),
      .cs_n   (spi_cs_n),
      .mosi   (spi_mosi),
      .rx_byte(rx_byte),
      .fin    (fin)
   );
endmodule

// File: rtl/spi_block_erase_chk.sv
module spi_block_erase_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic timeout,
   input logic sck,
   input logic cs_n,
   input logic mosi
);
   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R2

   AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck); // R5

   AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi)); // R5

   AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_TIMEOUT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (!busy && !done)); // R9

   AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout)); // R10
endmodule

bind spi_block_erase spi_block_erase_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .timeout(timeout),
   .sck    (spi_sck),
   .cs_n   (spi_cs_n),
   .mosi   (spi_mosi)
);

// File: tb/spi_block_erase_tb.sv
module spi_block_erase_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        size64 = 1'b0;
   logic [23:0] blk_addr = '0;
   logic [7:0]  clk_div = 8'd2;
   logic [7:0]  cs_gap = 8'd1;
   logic [15:0] poll_limit = 16'd1;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        busy, done, timeout;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   spi_block_erase dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .size64    (size64),
      .blk_addr  (blk_addr),
      .clk_div   (clk_div),
      .cs_gap    (cs_gap),
      .poll_limit(poll_limit),
      .spi_sck   (spi_sck),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .busy      (busy),
      .done      (done),
      .timeout   (timeout)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural flash model and per-clock protocol reference
   int          fr_len[$];
   logic [31:0] fr_dat[$];
   int          gap_q[$];
   int          busy_left = 0;
   int          nb = 0;
   int          hi_cnt = 0;
   int          cs_hi = 0;
   int          done_seen = 0;
   int          tmo_seen = 0;
   logic [31:0] sh = '0;
   logic [7:0]  op_cur = '0;
   logic [7:0]  stat = '0;
   logic        p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, p_done = 1'b0;
   logic        p_busy = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(!(spi_cs_n && spi_sck), "R5", "sck high while deselected", spi_sck, 0);
         if (spi_sck && p_sck)
            chk(spi_mosi == p_mosi, "R5", "mosi moved in high phase", spi_mosi, p_mosi);
         chk(!(done && timeout), "R10", "done with timeout", 1, 0);
         if (done) begin
            done_seen++;
            chk(!busy && !p_done, "R8", "done pulse shape/busy", {p_done, busy}, 0);
         end
         if (timeout) begin
            tmo_seen++;
            chk(!busy, "R9", "busy at timeout", busy, 0);
         end
         if (p_busy && !busy)
            chk(done || timeout, "R8", "busy fell without end pulse", 0, 1);
         if (!spi_cs_n && p_cs) begin
            gap_q.push_back(cs_hi);
            nb = 0; op_cur = '0; sh = '0;
         end
         if (spi_cs_n) cs_hi++;
         else          cs_hi = 0;
         if (!spi_cs_n) begin
            if (spi_sck && !p_sck) begin
               sh = {sh[30:0], spi_mosi};
               nb++;
               hi_cnt = 1;
               if (nb == 8) op_cur = sh[7:0];
            end else if (spi_sck) begin
               hi_cnt++;
            end
            if (!spi_sck && p_sck) begin
               chk(hi_cnt == int'(clk_div) + 1, "R5", "sck high length", hi_cnt, clk_div + 1);
               if (op_cur == 8'h05 && nb >= 8 && nb < 16) begin
                  if (nb == 8) stat = (busy_left > 0) ? 8'hFF : 8'hFE;
                  spi_miso = stat[15 - nb];
               end
            end
         end
         if (spi_cs_n && !p_cs) begin
            fr_len.push_back(nb);
            fr_dat.push_back(sh);
            if (op_cur == 8'h05 && busy_left > 0) busy_left--;
            spi_miso = 1'b0;
         end
      end
      p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi;
      p_done = done; p_busy = busy;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run_erase(input bit s64, input logic [23:0] a, input int div,
                            input int gap, input int lim, input int breads,
                            input bit exp_tmo, input bit poke);
      int n_poll;
      int d0, t0;
      int eff_gap;
      logic [7:0] op;
      n_poll  = exp_tmo ? ((lim == 0) ? 1 : lim) : breads + 1;
      eff_gap = (gap == 0) ? 1 : gap;
      op      = s64 ? 8'hD8 : 8'h52;
      fr_len.delete(); fr_dat.delete(); gap_q.delete();
      busy_left = breads;
      d0 = done_seen; t0 = tmo_seen;
      @(negedge clk);
      size64 = s64; blk_addr = a; clk_div = 8'(div); cs_gap = 8'(gap);
      poll_limit = 16'(lim); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1; blk_addr = ~a; size64 = ~s64;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && !timeout) @(negedge clk);
      repeat (2 * (div + 1) * 20 + 10) @(negedge clk);
      chk(!busy && spi_cs_n, "R2", "idle after end", {busy, spi_cs_n}, 1);
      chk(fr_len.size() == 2 + n_poll, "R2", "frame count", fr_len.size(), 2 + n_poll);
      if (fr_len.size() >= 2) begin
         chk(fr_len[0] == 8, "R3", "enable frame length", fr_len[0], 8);
         chk(fr_dat[0][7:0] == 8'h06, "R3", "enable opcode", fr_dat[0][7:0], 8'h06);
         chk(fr_len[1] == 32, "R4", "erase frame length", fr_len[1], 32);
         chk(fr_dat[1] == {op, a}, "R4", "erase frame bits", fr_dat[1], {op, a});
      end
      for (int i = 2; i < fr_len.size(); i++) begin
         chk(fr_len[i] == 16, "R7", "poll frame length", fr_len[i], 16);
         chk(fr_dat[i][15:8] == 8'h05, "R7", "poll opcode", fr_dat[i][15:8], 8'h05);
      end
      for (int i = 1; i < gap_q.size(); i++)
         chk(gap_q[i] >= eff_gap, "R6", "deselect gap", gap_q[i], eff_gap);
      chk(done_seen - d0 == (exp_tmo ? 0 : 1), "R8", "done pulses",
          done_seen - d0, exp_tmo ? 0 : 1);
      chk(tmo_seen - t0 == (exp_tmo ? 1 : 0), "R9", "timeout pulses",
          tmo_seen - t0, exp_tmo ? 1 : 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "bus idle in reset",
          {spi_cs_n, spi_sck}, 2'b10);
      chk(!busy && !done && !timeout, "R1", "flags in reset",
          {busy, done, timeout}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1'b1 && !busy, "R1", "idle after reset", {spi_cs_n, busy}, 2'b10);
      // 32 KB, low address bits set, two busy reads, extra start injected
      run_erase(1'b0, 24'h123456, 2, 3, 10, 2, 1'b0, 1'b1);
      // 64 KB, ready at first read, zero gap setting
      run_erase(1'b1, 24'hABCDEF, 3, 0, 5, 0, 1'b0, 1'b0);
      // timeout exactly at limit of 3
      run_erase(1'b0, 24'h7FFFFF, 2, 5, 3, 100, 1'b1, 1'b0);
      // limit 0 behaves as 1
      run_erase(1'b1, 24'h000001, 2, 2, 0, 100, 1'b1, 1'b0);
      // ready on the last permitted read
      run_erase(1'b1, 24'h3C0F81, 5, 1, 4, 3, 1'b0, 1'b0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule